// File: doc/BRIEF.md
# Bidirectional Parity Bus Transceiver

This block is a purely combinational bus transceiver made of independent sections. Each section carries a data byte between an A side and a B side, in a direction picked by its own direction input, and each has an input that releases both sides and the parity pin at once. The bidirectional lines are split into an input value, an output value and an output-enable, so the pads or bus keepers around the block can resolve the bus.

Each section also carries one parity line whose role follows the data direction. When the section transmits, it drives a parity bit computed from the A-side data. When it receives, it samples the parity line and checks it against the B-side data. A run-time input picks odd or even sense, and an active-low error output flags a received word whose ones count does not match that sense.

Top module: `parity_xcvr`

## Requirements
- R1: With `sec_float` low and `sec_tx` high (transmit), `b_oe` is 1, `a_oe` is 0, `b_out` equals `a_in` and `a_out` reads all zeros.
- R2: With `sec_float` low and `sec_tx` low (receive), `a_oe` is 1, `b_oe` is 0, `a_out` equals `b_in` and `b_out` reads all zeros.
- R3: With `sec_float` high, `a_oe`, `b_oe` and `par_oe` are all 0, and `a_out`, `b_out` and `par_out` read zero, whatever the direction.
- R4: In transmit, `par_oe` is 1 and `par_out` makes the ones count of the 8 A bits plus the parity bit odd when `sec_odd` is 1 and even when it is 0 (5 ones with even sense gives 1).
- R5: In receive, `par_oe` is 0 and `par_out` reads zero; `par_in` is used only as the received parity bit.
- R6: In receive, `err_n` is 0 when the ones count of the 8 `b_in` bits plus `par_in` fails the sense chosen by `sec_odd` (1 = odd, 0 = even), and 1 when it meets it.
- R7: In transmit, `err_n` is 1 for every data and sense value.
- R8: With `sec_float` high, `err_n` is 1 for every data, parity and sense value.
- R9: Each section's outputs depend only on that section's own inputs; section i uses bits `[8*i+7:8*i]` of the data buses and bit i of the control, parity and error vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sec_tx | input | S | Per-section direction: 1 = A to B, 0 = B to A |
| sec_float | input | S | Per-section release: 1 = nothing driven, error forced off |
| sec_odd | input | S | Per-section parity sense: 1 = odd, 0 = even |
| a_in | input | S*W | Values seen on the A sides |
| a_out | output | S*W | Values to drive onto the A sides |
| a_oe | output | S | Drive enables for the A sides |
| b_in | input | S*W | Values seen on the B sides |
| b_out | output | S*W | Values to drive onto the B sides |
| b_oe | output | S | Drive enables for the B sides |
| par_in | input | S | Values seen on the parity lines |
| par_out | output | S | Generated parity bits |
| par_oe | output | S | Drive enables for the parity lines |
| err_n | output | S | Per-section parity error, active low |

## Verification
Section 0 can transmit and generate parity at the same moment as section 1 receives a word with a parity error, and the reverse. Every sweep of one section over all 256 data values, both directions, both senses, both parity-in levels and both release levels holds the other section in the opposite direction with a deliberately bad parity bit. Each vector is judged by comparing both sections against a ones-counting model in the bench, so a fault in the error path of one section or a leak between sections shows up as a mismatch on the section that was held still.

// File: rtl/xcvr_pkg.sv
// Package: shared defaults and the direction type for the parity transceiver.
// Assumes: nothing beyond IEEE 1800-2017.
package xcvr_pkg;

    localparam int unsigned DEF_WIDTH    = 8;
    localparam int unsigned DEF_SECTIONS = 2;

    // Direction of a section; the encoding matches the sec_tx input level.
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

endpackage

// File: rtl/parity_tree.sv
// Module: parity_tree
// Computes the XOR of all bits of a word as a linear chain built by generate.
// Assumes: W >= 1. Output is 1 when the word holds an odd number of ones.
module parity_tree #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] data,
    output logic         odd_out
);

    logic [W-1:0] chain;

    // Seed the chain with the lowest bit.
    assign chain[0] = data[0];

    generate
        for (genvar i = 1; i < W; i++) begin : g_link
            // Fold one more bit into the running XOR.
            assign chain[i] = chain[i-1] ^ data[i];
        end
    endgenerate

    assign odd_out = chain[W-1];

endmodule

// File: rtl/xcvr_section.sv
// Module: xcvr_section
// One transceiver section: steers data A->B or B->A, generates parity from
// the A side in transmit, checks the B side against the incoming parity in
// receive, and releases every driver when the float input is high.
// Assumes: purely combinational; undriven output values are forced to zero.
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         tx,
    input  logic         flt,
    input  logic         odd,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         par_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         par_out,
    output logic         par_oe,
    output logic         err_n
);

    dir_e         dir;
    logic         a_xor;
    logic         gen_par;
    logic [W-1:0] chk_data;
    logic         chk_par;
    logic         chk_xor;
    logic         sense_ok;

    assign dir = tx ? DIR_TX : DIR_RX;

    // XOR of the A-side word feeds the generator.
    parity_tree #(.W(W)) u_gen_tree (
        .data    (a_in),
        .odd_out (a_xor)
    );

    // Generated bit: flip the raw XOR when odd sense is wanted.
    assign gen_par = a_xor ^ odd;

    // Pick the word and parity bit the checker looks at for this direction.
    always_comb begin
        if (dir == DIR_TX) begin
            chk_data = a_in;
            chk_par  = gen_par;
        end else begin
            chk_data = b_in;
            chk_par  = par_in;
        end
    end

    parity_tree #(.W(W)) u_chk_tree (
        .data    (chk_data),
        .odd_out (chk_xor)
    );

    // The nine-bit XOR must equal the chosen sense for the word to pass.
    assign sense_ok = ((chk_xor ^ chk_par) == odd);

    // Drive enables follow direction unless the section is released.
    always_comb begin
        a_oe   = !flt && (dir == DIR_RX);
        b_oe   = !flt && (dir == DIR_TX);
        par_oe = !flt && (dir == DIR_TX);
    end

    // Output values are gated by their enables so idle lanes read zero.
    always_comb begin
        a_out   = a_oe   ? b_in    : '0;
        b_out   = b_oe   ? a_in    : '0;
        par_out = par_oe ? gen_par : 1'b0;
    end

    // Error is held off while released; otherwise it reports the check.
    assign err_n = flt | sense_ok;

endmodule

// File: rtl/parity_xcvr.sv
// Module: parity_xcvr (top)
// A set of S independent parity transceiver sections, each W bits wide,
// with every bidirectional line split into input, output and enable.
// Assumes: purely combinational; section i owns data slice [W*i +: W] and
// bit i of every per-section vector.
module parity_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH,
    parameter int unsigned S = DEF_SECTIONS
) (
    input  logic [S-1:0]   sec_tx,
    input  logic [S-1:0]   sec_float,
    input  logic [S-1:0]   sec_odd,
    input  logic [S*W-1:0] a_in,
    output logic [S*W-1:0] a_out,
    output logic [S-1:0]   a_oe,
    input  logic [S*W-1:0] b_in,
    output logic [S*W-1:0] b_out,
    output logic [S-1:0]   b_oe,
    input  logic [S-1:0]   par_in,
    output logic [S-1:0]   par_out,
    output logic [S-1:0]   par_oe,
    output logic [S-1:0]   err_n
);

    generate
        for (genvar s = 0; s < S; s++) begin : g_sec
            // One section per slice; no signal crosses between slices.
            xcvr_section #(.W(W)) u_sec (
                .tx      (sec_tx[s]),
                .flt     (sec_float[s]),
                .odd     (sec_odd[s]),
                .a_in    (a_in[W*s +: W]),
                .b_in    (b_in[W*s +: W]),
                .par_in  (par_in[s]),
                .a_out   (a_out[W*s +: W]),
                .a_oe    (a_oe[s]),
                .b_out   (b_out[W*s +: W]),
                .b_oe    (b_oe[s]),
                .par_out (par_out[s]),
                .par_oe  (par_oe[s]),
                .err_n   (err_n[s])
            );
        end
    endgenerate

endmodule

// File: rtl/parity_xcvr_chk.sv
// Module: parity_xcvr_chk
// Immediate assertions over the ports of parity_xcvr, one set per section.
// Assumes: the block has no clock, so checks run whenever inputs settle;
// vectors carrying X or Z are skipped.
module parity_xcvr_chk #(
    parameter int unsigned W = 8,
    parameter int unsigned S = 2
) (
    input logic [S-1:0]   sec_tx,
    input logic [S-1:0]   sec_float,
    input logic [S-1:0]   sec_odd,
    input logic [S*W-1:0] a_in,
    input logic [S*W-1:0] a_out,
    input logic [S-1:0]   a_oe,
    input logic [S*W-1:0] b_in,
    input logic [S*W-1:0] b_out,
    input logic [S-1:0]   b_oe,
    input logic [S-1:0]   par_in,
    input logic [S-1:0]   par_out,
    input logic [S-1:0]   par_oe,
    input logic [S-1:0]   err_n
);

    generate
        for (genvar s = 0; s < S; s++) begin : g_chk
            // Check one section whenever its ports change.
            always_comb begin
                if (!$isunknown({sec_tx[s], sec_float[s], sec_odd[s], a_in[W*s +: W],
                                 b_in[W*s +: W], par_in[s]})) begin
                    // R1
                    tx_route_chk: assert (!(sec_tx[s] && !sec_float[s]) ||
                        (b_oe[s] && !a_oe[s] && b_out[W*s +: W] == a_in[W*s +: W] &&
                         a_out[W*s +: W] == '0))
                        else $error("R1 transmit routing broken in section %0d", s);
                    // R2
                    rx_route_chk: assert (!(!sec_tx[s] && !sec_float[s]) ||
                        (a_oe[s] && !b_oe[s] && a_out[W*s +: W] == b_in[W*s +: W] &&
                         b_out[W*s +: W] == '0))
                        else $error("R2 receive routing broken in section %0d", s);
                    // R1 R2: the two sides never drive together
                    side_excl_chk: assert ($onehot0({a_oe[s], b_oe[s]}))
                        else $error("R1/R2 both sides driven in section %0d", s);
                    // R3
                    float_quiet_chk: assert (!sec_float[s] ||
                        (!a_oe[s] && !b_oe[s] && !par_oe[s] && !par_out[s] &&
                         a_out[W*s +: W] == '0 && b_out[W*s +: W] == '0))
                        else $error("R3 released section %0d still drives", s);
                    // R4
                    gen_sense_chk: assert (!(sec_tx[s] && !sec_float[s]) ||
                        (par_oe[s] && ((^{a_in[W*s +: W], par_out[s]}) == sec_odd[s])))
                        else $error("R4 generated parity wrong in section %0d", s);
                    // R5
                    rx_par_idle_chk: assert (sec_tx[s] || (!par_oe[s] && !par_out[s]))
                        else $error("R5 parity line driven in receive, section %0d", s);
                    // R6
                    rx_err_chk: assert (sec_tx[s] || sec_float[s] ||
                        (err_n[s] == ((^{b_in[W*s +: W], par_in[s]}) == sec_odd[s])))
                        else $error("R6 receive error flag wrong in section %0d", s);
                    // R7 R8
                    err_off_chk: assert (!(sec_tx[s] || sec_float[s]) || err_n[s])
                        else $error("R7/R8 error flag active in section %0d", s);
                end
            end
        end
    endgenerate

endmodule

bind parity_xcvr parity_xcvr_chk #(.W(W), .S(S)) u_chk (
    .sec_tx    (sec_tx),
    .sec_float (sec_float),
    .sec_odd   (sec_odd),
    .a_in      (a_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_in      (b_in),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .par_in    (par_in),
    .par_out   (par_out),
    .par_oe    (par_oe),
    .err_n     (err_n)
);

// File: tb/parity_xcvr_test.sv
// Directed bench for parity_xcvr: one task per scenario, each checking its
// own results against a ones-counting model. Inputs change on the falling
// edge, outputs are sampled 2 ns later.
module parity_xcvr_test;

    localparam int W = 8;
    localparam int S = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [S-1:0]   sec_tx, sec_float, sec_odd, par_in;
    logic [S*W-1:0] a_in, b_in;
    logic [S*W-1:0] a_out, b_out;
    logic [S-1:0]   a_oe, b_oe, par_out, par_oe, err_n;

    int checks = 0;
    int errors = 0;

    parity_xcvr #(.W(W), .S(S)) uut (
        .sec_tx    (sec_tx),
        .sec_float (sec_float),
        .sec_odd   (sec_odd),
        .a_in      (a_in),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_in      (b_in),
        .b_out     (b_out),
        .b_oe      (b_oe),
        .par_in    (par_in),
        .par_out   (par_out),
        .par_oe    (par_oe),
        .err_n     (err_n)
    );

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_sec(input int s, input bit tx, input bit flt, input bit odd,
                           input bit par, input logic [W-1:0] a, input logic [W-1:0] b);
        sec_tx[s]       = tx;
        sec_float[s]    = flt;
        sec_odd[s]      = odd;
        par_in[s]       = par;
        a_in[W*s +: W]  = a;
        b_in[W*s +: W]  = b;
    endtask

    // Compare one section against the model for the given stimulus.
    task automatic check_sec(input int s, input bit tx, input bit flt, input bit odd,
                             input bit par, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] ao, bo;
        bit exp_par, exp_ok;
        int tot;
        ao = a_out[W*s +: W];
        bo = b_out[W*s +: W];
        if (flt) begin
            chk({a_oe[s], b_oe[s], par_oe[s]} == 3'b000, "R3", "enables while released",
                {a_oe[s], b_oe[s], par_oe[s]}, 0);
            chk(ao == '0 && bo == '0 && !par_out[s], "R3", "values while released",
                {ao, bo, 7'd0, par_out[s]}, 0);
            chk(err_n[s] == 1'b1, "R8", "err_n while released", err_n[s], 1);
        end else if (tx) begin
            chk(b_oe[s] && !a_oe[s], "R1", "tx enables", {a_oe[s], b_oe[s]}, 2'b01);
            chk(bo == a && ao == '0, "R1", "tx data", {ao, bo}, {8'd0, a});
            // odd sense: total must be odd; even sense: total must be even
            exp_par = odd ? (ones(a) % 2 == 0) : (ones(a) % 2 == 1);
            chk(par_oe[s] && par_out[s] == exp_par, "R4", "generated parity",
                {par_oe[s], par_out[s]}, {1'b1, exp_par});
            chk(err_n[s] == 1'b1, "R7", "err_n in tx", err_n[s], 1);
        end else begin
            chk(a_oe[s] && !b_oe[s], "R2", "rx enables", {a_oe[s], b_oe[s]}, 2'b10);
            chk(ao == b && bo == '0, "R2", "rx data", {ao, bo}, {b, 8'd0});
            chk(!par_oe[s] && !par_out[s], "R5", "parity line in rx",
                {par_oe[s], par_out[s]}, 0);
            tot = ones(b) + int'(par);
            exp_ok = odd ? (tot % 2 == 1) : (tot % 2 == 0);
            chk(err_n[s] == exp_ok, "R6", "err_n in rx", err_n[s], exp_ok);
        end
    endtask

    // Scenario: everything released at start-up gives a quiet bus.
    task automatic t_start_quiet();
        @(negedge clk);
        for (int s = 0; s < S; s++) set_sec(s, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C);
        #2;
        for (int s = 0; s < S; s++) check_sec(s, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C);
    endtask

    // Scenario: five ones with even sense must generate a 1 (R4).
    task automatic t_five_ones_even();
        @(negedge clk);
        set_sec(0, 1'b1, 1'b0, 1'b0, 1'b0, 8'b1011_0101, 8'h00);
        set_sec(1, 1'b1, 1'b0, 1'b1, 1'b0, 8'b1011_0101, 8'h00);
        #2;
        chk(par_out[0] == 1'b1, "R4", "5 ones even sense", par_out[0], 1);
        chk(par_out[1] == 1'b0, "R4", "5 ones odd sense", par_out[1], 0);
    endtask

    // Scenario: sweep one section while the other is held in the opposite
    // direction with a bad parity bit; both are checked on every vector (R9).
    task automatic t_sweep(input int s);
        int o;
        bit o_tx, o_par;
        logic [W-1:0] o_b;
        o = (s == 0) ? 1 : 0;
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int d = 0; d < 256; d++) begin
                bit tx, flt, odd, par;
                logic [W-1:0] a, b;
                tx  = cfg[0];
                flt = cfg[1];
                odd = cfg[2];
                par = cfg[3];
                a   = d[W-1:0];
                b   = ~d[W-1:0] ^ 8'h5A;
                o_tx  = !tx;
                o_b   = 8'h07;
                o_par = 1'b0;  // 3 ones + 0 fails odd? no: even-sense check below
                @(negedge clk);
                set_sec(s, tx, flt, odd, par, a, b);
                // even sense, 3 ones + parity 0 = odd total, so the held
                // section reports an error while receiving
                set_sec(o, o_tx, 1'b0, 1'b0, o_par, 8'hC3, o_b);
                #2;
                check_sec(s, tx, flt, odd, par, a, b);
                check_sec(o, o_tx, 1'b0, 1'b0, o_par, 8'hC3, o_b);
                if (!o_tx)
                    chk(err_n[o] == 1'b0, "R9", "held section error kept", err_n[o], 0);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_start_quiet();
        t_five_ones_even();
        t_sweep(0);
        t_sweep(1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule